// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the system clock. The division has two stages. A 2-bit code picks a prescale factor of 2, 3, 5 or 7. A scale code then picks an even factor. A double-rate control halves the product, so odd total ratios become possible. When the total ratio is odd, the output is high for the shorter part of each period. For example, a total ratio of 3 gives one cycle high and two cycles low.

The block produces the clock level and two one-cycle strobes. The strobes mark the rising and falling transitions, so the shift logic can launch and capture data without detecting edges itself. The divider configuration is captured while the block is idle. A run starts when `enable` rises, and the clock stays low until `enable` falls and rises again.

Top module: `spi_baud_gen`

## Requirements
- R1: While `rstN` is low, `sckOut`, `sckRise` and `sckFall` are 0.
- R2: Prescaler code `prescCode` values 0, 1, 2, 3 select factors 2, 3, 5, 7.
- R3: Scale code `scaleCode` values 0 to 3 select factors 2, 4, 6, 8. A value c of 4 or more selects 2 to the power c (16, 32, 64, ...).
- R4: With `dblRate` = 0, the clock period in system cycles is N = prescale factor × scale factor. The clock is high for exactly N/2 cycles of each period.
- R5: With `dblRate` = 1, the period is N = prescale × scale / 2. The clock is high for floor(N/2) cycles and low for the remaining cycles, so a ratio of 3 gives 1 cycle high and 2 cycles low.
- R6: After the first rising clock edge that samples `enable` high, the clock stays low for N − floor(N/2) cycles and then rises. It then repeats with period N.
- R7: `sckRise` is high for exactly the single cycle in which `sckOut` has just gone from 0 to 1. `sckFall` is high for exactly the single cycle in which `sckOut` has just gone from 1 to 0.
- R8: One clock edge after `enable` is sampled low, `sckOut`, `sckRise` and `sckFall` are 0, and the internal count is cleared. A new run then starts with the full low phase of R6.
- R9: The codes and `dblRate` are captured only while `enable` is low. Changes made while `enable` is high do not affect the clock until the next run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run the divider; low holds it idle |
| prescCode | input | 2 | Prescale factor select |
| scaleCode | input | SCALE_CODE_W (4) | Scale factor select |
| dblRate | input | 1 | Halve the total division ratio |
| sckOut | output | 1 | Serial clock level, idle low |
| sckRise | output | 1 | One-cycle strobe with the clock's rising transition |
| sckFall | output | 1 | One-cycle strobe with the clock's falling transition |

## Verification
The counter, the edge decode and the output register add up to one register stage. As a result, the level and both strobes seen after clock edge k of a run reflect count value (k−1) mod N. The first rise is due after edge N − floor(N/2), and an idle level is due one edge after `enable` drops. The bench drives all inputs and samples all outputs on the falling edge. In every sampled cycle it compares the level and both strobes against that formula, using ratios it derives from the code tables on its own. Mid-run code changes are checked against the configuration captured before the run.

// File: rtl/spi_baud_gen_pkg.sv
package spi_baud_gen_pkg;

  typedef struct packed {
    logic setHigh;
    logic setLow;
  } edgeCmd_t;

  function automatic int prescFactor(input int code);
    case (code)
      0: prescFactor = 2;
      1: prescFactor = 3;
      2: prescFactor = 5;
      default: prescFactor = 7;
    endcase
  endfunction

  function automatic int scaleFactor(input int code);
    if (code < 4) scaleFactor = 2 * (code + 1);
    else          scaleFactor = 1 << code;
  endfunction

endpackage

// File: rtl/spi_baud_ctrl.sv
module spi_baud_ctrl
  import spi_baud_gen_pkg::*;
#(
  parameter int SCALE_CODE_W = 4,
  parameter int CNT_W        = 19
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [1:0]              prescCode,
  input  logic [SCALE_CODE_W-1:0] scaleCode,
  input  logic                    dblRate,
  output edgeCmd_t                cmd
);

  int               ratioInt;
  logic [CNT_W-1:0] totalD;
  logic [CNT_W-1:0] lowD;
  logic [CNT_W-1:0] totalQ;
  logic [CNT_W-1:0] lowQ;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    ratioInt = prescFactor(int'(prescCode)) * scaleFactor(int'(scaleCode));
    if (dblRate) ratioInt = ratioInt / 2;
    totalD = CNT_W'(ratioInt);
    lowD   = totalD - (totalD >> 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      totalQ <= CNT_W'(2);
      lowQ   <= CNT_W'(1);
    end else if (!enable) begin
      cnt    <= '0;
      totalQ <= totalD;
      lowQ   <= lowD;
    end else if (cnt == totalQ - CNT_W'(1)) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_comb begin
    cmd.setHigh = enable && (cnt == lowQ - CNT_W'(1));
    cmd.setLow  = enable && (cnt == totalQ - CNT_W'(1));
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (cnt < totalQ)); // R6

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    $past(enable) && enable |-> $stable(totalQ) && $stable(lowQ)); // R9

  AST_CMD_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.setHigh && cmd.setLow)); // R7

endmodule

// File: rtl/spi_baud_dp.sv
module spi_baud_dp
  import spi_baud_gen_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     enable,
  input  edgeCmd_t cmd,
  output logic     sckOut,
  output logic     sckRise,
  output logic     sckFall
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckOut  <= 1'b0;
      sckRise <= 1'b0;
      sckFall <= 1'b0;
    end else if (!enable) begin
      sckOut  <= 1'b0;
      sckRise <= 1'b0;
      sckFall <= 1'b0;
    end else begin
      sckRise <= cmd.setHigh;
      sckFall <= cmd.setLow;
      if (cmd.setHigh)     sckOut <= 1'b1;
      else if (cmd.setLow) sckOut <= 1'b0;
    end
  end

  AST_RISE_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sckRise |-> sckOut && !$past(sckOut)); // R7

  AST_FALL_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    sckFall |-> !sckOut && $past(sckOut)); // R7

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sckOut && !sckRise && !sckFall); // R8

endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_baud_gen_pkg::*;
#(
  parameter int SCALE_CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    enable,
  input  logic [1:0]              prescCode,
  input  logic [SCALE_CODE_W-1:0] scaleCode,
  input  logic                    dblRate,
  output logic                    sckOut,
  output logic                    sckRise,
  output logic                    sckFall
);

  localparam int MAX_SCALE_LOG = (1 << SCALE_CODE_W) - 1;
  localparam int CNT_W         = MAX_SCALE_LOG + 4;

  edgeCmd_t cmd;

  spi_baud_ctrl #(
    .SCALE_CODE_W(SCALE_CODE_W),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .enable   (enable),
    .prescCode(prescCode),
    .scaleCode(scaleCode),
    .dblRate  (dblRate),
    .cmd      (cmd)
  );

  spi_baud_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .cmd    (cmd),
    .sckOut (sckOut),
    .sckRise(sckRise),
    .sckFall(sckFall)
  );

endmodule

// File: tb/tb_spi_baud_gen.sv
module tb_spi_baud_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] prescCode = 2'd0;
  logic [3:0] scaleCode = 4'd0;
  logic       dblRate = 1'b0;
  logic       sckOut, sckRise, sckFall;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  spi_baud_gen dut (
    .clk(clk), .rstN(rstN), .enable(enable), .prescCode(prescCode),
    .scaleCode(scaleCode), .dblRate(dblRate),
    .sckOut(sckOut), .sckRise(sckRise), .sckFall(sckFall)
  );

  function automatic int expRatio(input int p, input int s, input int d);
    int pv;
    int sv;
    int n;
    pv = (p == 0) ? 2 : (p == 1) ? 3 : (p == 2) ? 5 : 7;
    sv = (s <= 3) ? (2 + 2 * s) : (2 ** s);
    n  = pv * sv;
    return (d != 0) ? n / 2 : n;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string tag, input int k, input int n);
    int ce;
    int lowLen;
    ce     = (k - 1) % n;
    lowLen = n - n / 2;
    chk(tag, "sckOut",  int'(sckOut),  int'(ce >= lowLen - 1 && ce <= n - 2));
    chk(tag, "sckRise", int'(sckRise), int'(ce == lowLen - 1));
    chk(tag, "sckFall", int'(sckFall), int'(ce == n - 1));
  endtask

  // Configure while idle, run for two periods plus a few cycles, compare every cycle.
  task automatic runCase(input int p, input int s, input int d, input string tag,
                         input bit changeMid);
    int n;
    n = expRatio(p, s, d);
    @(negedge clk);
    enable = 1'b0; prescCode = 2'(p); scaleCode = 4'(s); dblRate = d[0];
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 2 * n + 3; k++) begin
      @(negedge clk);
      checkOutputs(tag, k, n);
      if (changeMid && k == 3) begin
        prescCode = ~prescCode; scaleCode = scaleCode ^ 4'd3; dblRate = ~dblRate;
      end
    end
    enable = 1'b0;
    @(negedge clk);
    chk("R8", "idle sckOut", int'(sckOut), 0);
    chk("R8", "idle strobes", int'(sckRise | sckFall), 0);
  endtask

  task automatic checkReset();
    #1;
    chk("R1", "reset sckOut", int'(sckOut), 0);
    chk("R1", "reset sckRise", int'(sckRise), 0);
    chk("R1", "reset sckFall", int'(sckFall), 0);
    repeat (3) @(negedge clk);
    chk("R1", "reset held sckOut", int'(sckOut), 0);
    rstN = 1'b1;
  endtask

  // Drop enable in the high phase, then confirm idle and a fresh full low phase.
  task automatic disableMid();
    @(negedge clk);
    enable = 1'b0; prescCode = 2'd0; scaleCode = 4'd1; dblRate = 1'b0;
    @(negedge clk);
    enable = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      checkOutputs("R8", k, 8);
    end
    chk("R8", "high before drop", int'(sckOut), 1);
    enable = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R8", "dropped sckOut", int'(sckOut), 0);
      chk("R8", "dropped strobes", int'(sckRise | sckFall), 0);
    end
    runCase(0, 1, 0, "R8_R6", 1'b0);
  endtask

  initial begin
    #1500000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checkReset();
    runCase(0, 0, 0, "R4_R2_R6", 1'b0);  // ratio 4
    runCase(1, 0, 1, "R5_R2_R7", 1'b0);  // ratio 3, 1 high 2 low
    runCase(0, 0, 1, "R5_R6", 1'b0);     // ratio 2
    runCase(2, 1, 0, "R4_R2_R3", 1'b0);  // ratio 20
    runCase(3, 2, 1, "R5_R2_R3", 1'b0);  // ratio 21, odd
    runCase(0, 3, 0, "R4_R3", 1'b0);     // ratio 16
    runCase(0, 4, 1, "R5_R3", 1'b0);     // ratio 16 via scale 16
    runCase(1, 5, 0, "R4_R3_R7", 1'b0);  // ratio 96
    runCase(1, 1, 0, "R9", 1'b1);        // codes change mid-run, ratio stays 12
    runCase(0, 0, 1, "R9_R6", 1'b0);     // new codes take effect next run
    disableMid();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule